// File: doc/BRIEF.md
# Self-Repairing Five-State Counter

This block is a synchronous divide-by-five counter. It steps through five 3-bit codes that are not in plain binary order, and the register contents drive the output directly, so no output decode is needed. Three of the eight 3-bit codes are not part of the count sequence. The next-state logic spells out a successor for every one of the eight codes, with no don't-care choices. Because of this, a register that starts up on an unused code rejoins the sequence on the first enabled clock edge.

A synchronous clear is built from gating in front of the register inputs and loads the zero code. Flip-flop set and reset pins are never used. An enable input advances the count. While enable is low, the code holds, and this includes an unused code. A one-cycle wrap pulse marks each completed cycle. The power-up value of the register is a parameter, `INIT_CODE`. It exists so that start-up on any code, legal or not, can be exercised through the ports.

Top module: `mod5_recover_counter`

## Requirements
- R1: With en=1 and clr=0, each rising edge moves count along the loop 000 -> 001 -> 011 -> 111 -> 100 -> 000. Bit 2 of count is the most significant bit.
- R2: With en=1 and clr=0, an edge taken while count is the unused code 101 loads 100.
- R3: With en=1 and clr=0, an edge taken while count is the unused code 010 loads 011.
- R4: With en=1 and clr=0, an edge taken while count is the unused code 110 loads 100.
- R5: With clr=1, every rising edge loads 000, whatever en is and whatever the current code is, legal or unused. The same edge leaves wrap at 0.
- R6: With en=0 and clr=0, count keeps its value across edges, and this includes the unused codes.
- R7: wrap is 1 for exactly the one cycle that follows an edge at which count advanced from 100 to 000 with en=1 and clr=0. It is 0 after every other edge, including a clear taken from 100 and a repair into 100.
- R8: Before the first clock edge, count equals the parameter `INIT_CODE` (default 000) and wrap is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear to 000; overrides en |
| en | input | 1 | Advance enable |
| count | output | 3 | Current state code, which is also the count value |
| wrap | output | 1 | One-cycle pulse after the 100 -> 000 step |

## Verification
Both count and wrap are registered. Each result is therefore due exactly one rising edge after the en and clr values that produced it. The driver changes inputs on the falling edge and queues the expected pair just after the next rising edge. The monitor compares that pair on the falling edge that follows, half a period after the register has settled. Start-up on each unused code is reached through extra instances with different `INIT_CODE` values. These are sampled on falling edges only, one edge after each stimulus.

// File: rtl/mod5r_pkg.sv
package mod5r_pkg;

  localparam int CODE_W = 3;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t C_S0 = 3'b000;
  localparam code_t C_S1 = 3'b001;
  localparam code_t C_S2 = 3'b011;
  localparam code_t C_S3 = 3'b111;
  localparam code_t C_S4 = 3'b100;
  localparam code_t C_X5 = 3'b101;
  localparam code_t C_X2 = 3'b010;
  localparam code_t C_X6 = 3'b110;

  // Every one of the eight codes gets an explicit successor.
  function automatic code_t succ(input code_t c);
    code_t r;
    case (c)
      C_S0:    r = C_S1;
      C_S1:    r = C_S2;
      C_S2:    r = C_S3;
      C_S3:    r = C_S4;
      C_S4:    r = C_S0;
      C_X5:    r = C_S4;
      C_X2:    r = C_S2;
      C_X6:    r = C_S4;
      default: r = C_S0;
    endcase
    return r;
  endfunction

  function automatic logic is_unused(input code_t c);
    return (c == C_X5) || (c == C_X2) || (c == C_X6);
  endfunction

endpackage

// File: rtl/mod5r_next.sv
module mod5r_next
  import mod5r_pkg::*;
(
  input  code_t cur,
  input  logic  clr,
  input  logic  en,
  output code_t nxt,
  output logic  wrap_evt,
  output logic  unused_now
);
  always_comb begin
    if (clr)      nxt = C_S0;
    else if (en)  nxt = succ(cur);
    else          nxt = cur;
  end

  assign wrap_evt   = en && !clr && (cur == C_S4);
  assign unused_now = is_unused(cur);
endmodule

// File: rtl/mod5r_reg.sv
module mod5r_reg #(
  parameter int W = 3,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r = INIT;
  always_ff @(posedge clk) q_r <= d;
  assign q = q_r;
endmodule

// File: rtl/mod5_recover_counter.sv
module mod5_recover_counter
  import mod5r_pkg::*;
#(
  parameter logic [2:0] INIT_CODE = 3'b000
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       en,
  output logic [2:0] count,
  output logic       wrap
);
  code_t state_q;
  code_t state_d;
  logic  wrap_evt;
  logic  unused_now;

  mod5r_next u_next (
    .cur(state_q), .clr(clr), .en(en),
    .nxt(state_d), .wrap_evt(wrap_evt), .unused_now(unused_now)
  );

  mod5r_reg #(.W(CODE_W), .INIT(INIT_CODE)) u_state (
    .clk(clk), .d(state_d), .q(state_q)
  );

  mod5r_reg #(.W(1), .INIT(1'b0)) u_wrap (
    .clk(clk), .d(wrap_evt), .q(wrap)
  );

  assign count = state_q;
endmodule

// File: rtl/mod5r_checker.sv
module mod5r_checker
  import mod5r_pkg::*;
(
  input logic       clk,
  input logic       clr,
  input logic       en,
  input logic [2:0] count,
  input logic       wrap,
  input logic       unused_now
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  logic adv;
  assign adv = en && !clr;

  a_r1_s0: assert property (@(posedge clk) disable iff (!armed)
    (adv && count == 3'b000) |=> count == 3'b001);
  a_r1_s1: assert property (@(posedge clk) disable iff (!armed)
    (adv && count == 3'b001) |=> count == 3'b011);
  a_r1_s2: assert property (@(posedge clk) disable iff (!armed)
    (adv && count == 3'b011) |=> count == 3'b111);
  a_r1_s3: assert property (@(posedge clk) disable iff (!armed)
    (adv && count == 3'b111) |=> count == 3'b100);
  a_r1_s4: assert property (@(posedge clk) disable iff (!armed)
    (adv && count == 3'b100) |=> count == 3'b000);
  a_r2_fix_101: assert property (@(posedge clk) disable iff (!armed)
    (adv && count == 3'b101) |=> count == 3'b100);
  a_r3_fix_010: assert property (@(posedge clk) disable iff (!armed)
    (adv && count == 3'b010) |=> count == 3'b011);
  a_r4_fix_110: assert property (@(posedge clk) disable iff (!armed)
    (adv && count == 3'b110) |=> count == 3'b100);
  a_r4_no_chain: assert property (@(posedge clk) disable iff (!armed)
    (adv && unused_now) |=> !unused_now);
  a_r5_clear: assert property (@(posedge clk) disable iff (!armed)
    clr |=> (count == 3'b000 && !wrap));
  a_r6_hold: assert property (@(posedge clk) disable iff (!armed)
    (!en && !clr) |=> $stable(count));
  a_r7_wrap_src: assert property (@(posedge clk) disable iff (!armed)
    wrap |-> ($past(count) == 3'b100 && $past(en) && !$past(clr)));
  a_r7_wrap_len: assert property (@(posedge clk) disable iff (!armed)
    wrap |=> !wrap);
endmodule

bind mod5_recover_counter mod5r_checker u_chk (
  .clk(clk), .clr(clr), .en(en), .count(count), .wrap(wrap),
  .unused_now(unused_now)
);

// File: tb/test_mod5_recover_counter.sv
`timescale 1ns/1ps
module test_mod5_recover_counter;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic clr = 0, en = 0;
  logic [2:0] count;
  logic wrap;
  mod5_recover_counter i_mod5_recover_counter (
    .clk(clk), .clr(clr), .en(en), .count(count), .wrap(wrap));

  logic ea = 0, eb = 0, ec = 0, ed = 0, cd = 0;
  logic [2:0] ca, cb, cc, cdq;
  logic wa, wb, wc, wd;
  mod5_recover_counter #(.INIT_CODE(3'b101)) i_p5 (
    .clk(clk), .clr(1'b0), .en(ea), .count(ca), .wrap(wa));
  mod5_recover_counter #(.INIT_CODE(3'b010)) i_p2 (
    .clk(clk), .clr(1'b0), .en(eb), .count(cb), .wrap(wb));
  mod5_recover_counter #(.INIT_CODE(3'b110)) i_p6 (
    .clk(clk), .clr(1'b0), .en(ec), .count(cc), .wrap(wc));
  mod5_recover_counter #(.INIT_CODE(3'b101)) i_c5 (
    .clk(clk), .clr(cd), .en(ed), .count(cdq), .wrap(wd));

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  typedef struct { logic [2:0] c; logic w; string tag; } exp_t;
  exp_t sb[$];
  logic [2:0] m_q = 3'b000;

  function automatic logic [2:0] model_next(input logic [2:0] c);
    case (c)
      3'b000: return 3'b001;
      3'b001: return 3'b011;
      3'b011: return 3'b111;
      3'b111: return 3'b100;
      3'b100: return 3'b000;
      3'b010: return 3'b011;
      default: return 3'b100;
    endcase
  endfunction

  task automatic drive(input logic e, input logic c, input string tag);
    logic [2:0] nq;
    logic nw;
    @(negedge clk);
    en = e; clr = c;
    nw = e && !c && (m_q == 3'b100);
    nq = c ? 3'b000 : (e ? model_next(m_q) : m_q);
    @(posedge clk);
    #1;
    m_q = nq;
    sb.push_back('{nq, nw, tag});
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, {wrap, count}, {e.w, e.c});
    end
  end

  initial begin
    #5;
    chk("R8 main init", {wrap, count}, 4'b0000);
    chk("R8 p5 init", {wa, ca}, 4'b0101);
    chk("R8 p2 init", {wb, cb}, 4'b0010);
    chk("R8 p6 init", {wc, cc}, 4'b0110);
    @(negedge clk);
    chk("R6 hold 110", {1'b0, cc}, 4'b0110);
    chk("R6 hold 101", {1'b0, ca}, 4'b0101);
    ea = 1; eb = 1; ec = 1; ed = 1; cd = 1;
    @(negedge clk);
    chk("R2 101->100", {wa, ca}, 4'b0100);
    chk("R3 010->011", {wb, cb}, 4'b0011);
    chk("R4 110->100", {wc, cc}, 4'b0100);
    chk("R5 clear from 101", {wd, cdq}, 4'b0000);
    cd = 0;
    @(negedge clk);
    chk("R7 wrap after repaired 100", {wa, ca}, 4'b1000);
    chk("R1 repaired 011->111", {1'b0, cb}, 4'b0111);
    ea = 0; eb = 0; ec = 0; ed = 0;

    drive(1'b0, 1'b1, "R5 clear at start");
    for (int i = 0; i < 12; i++) drive(1'b1, 1'b0, "R1 R7 cycle");
    drive(1'b0, 1'b0, "R6 hold");
    drive(1'b0, 1'b0, "R6 hold");
    drive(1'b1, 1'b1, "R5 clear beats en");
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, "R1 to 100");
    drive(1'b1, 1'b1, "R5 R7 clear at 100 no wrap");
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, "R1 to 100");
    drive(1'b0, 1'b0, "R6 hold at 100");
    drive(1'b0, 1'b0, "R6 hold at 100");
    drive(1'b1, 1'b0, "R7 wrap after hold");
    drive(1'b1, 1'b0, "R7 wrap drops");
    drive(1'b0, 1'b0, "R6 idle");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule